// File: doc/BRIEF.md
# Interrupt Status and Mask Register Set

This block collects up to `DATA_W` interrupt sources into one level-sensitive interrupt line. Each source has a sticky status bit, which a one-cycle event pulse or level on `evt_i` sets. Software clears a status bit by writing a one to it. Each source also has a mask bit. An unmasked status bit drives the interrupt output high.

Software never writes the mask directly. An unmask port clears mask bits and a mask port sets them. A test-injection port ORs a value into the status bits, so the interrupt path can be exercised without real events. Reads have no side effects. The read data is combinational from the addressed register. Writes take effect at the clock edge that samples them. The active-low reset asserts asynchronously and is released through a two-stage synchronizer.

Word offsets: status = 0, mask = 1, unmask = 2, mask-set = 3, inject = 4. Offsets 5 to 7 are unmapped.

Top module: `irq_mask_regs`

## Requirements
- R1: `irq_o` is high exactly when some bit of (status AND NOT mask) is 1. It reflects the register state from the same clock edge that updates status or mask.
- R2: A write of value V to offset 2 (unmask) clears every mask bit that is 1 in V. All other mask bits keep their value.
- R3: A write of value V to offset 3 (mask-set) sets every mask bit that is 1 in V. All other mask bits keep their value.
- R4: A write of value V to offset 4 (inject) ORs V into the status bits.
- R5: A write of value V to offset 0 clears every status bit that is 1 in V. Status bits that are 0 in V are unchanged.
- R6: A 1 on bit n of `evt_i` in a clock cycle sets status bit n at that edge. This holds even when the same cycle writes a clear to bit n.
- R7: While reset is asserted, and after it is released, status reads 0, mask reads all ones, and `irq_o` is 0.
- R8: Reads at offsets 2, 3, 4 and at unmapped offsets 5 to 7 return 0. A write to offset 1 (mask) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 3 | Word offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| evt_i | input | DATA_W | Hardware event inputs, one per status bit |
| irq_o | output | 1 | Level interrupt output |

## Verification
Every write and every event becomes visible at the rising edge that samples it. Status, mask and `irq_o` all change at that one edge. Read data follows `bus_addr` with no clock delay. For each case the bench therefore drives its inputs at a falling edge and lets one rising edge pass. At the next falling edge it samples `irq_o`, then moves `bus_addr` across the status and mask offsets, letting a short settling delay pass before each read. After reset is released, the bench waits three edges for the synchronizer before driving any traffic.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_UNMASK = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_MSET   = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_INJECT = 3'd4;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_ni,
  input  logic              clr_we,
  input  logic              inj_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evt_i,
  output logic [DATA_W-1:0] status_d,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] clr_bits;
  logic [DATA_W-1:0] set_bits;
  logic              st_en;

  always_comb begin
    clr_bits = clr_we ? wdata : '0;
    set_bits = evt_i | (inj_we ? wdata : '0);
    // set terms are applied after the clear so a same-cycle event wins
    status_d = (status_q & ~clr_bits) | set_bits;
    st_en    = clr_we | inj_we | (|evt_i);
  end

  always_ff @(posedge clk or negedge srst_ni) begin
    if (!srst_ni)   status_q <= '0;
    else if (st_en) status_q <= status_d;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_ni,
  input  logic              unmask_we,
  input  logic              mset_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] mask_q
);
  logic mk_en;

  always_comb begin
    mask_d = mask_q;
    if (unmask_we) mask_d = mask_q & ~wdata;
    if (mset_we)   mask_d = mask_q | wdata;
    mk_en = unmask_we | mset_we;
  end

  always_ff @(posedge clk or negedge srst_ni) begin
    if (!srst_ni)   mask_q <= '1;
    else if (mk_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_level_gen.sv
module irq_level_gen #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_ni,
  input  logic [DATA_W-1:0] status_d,
  input  logic [DATA_W-1:0] mask_d,
  output logic              irq_o
);
  logic irq_d;

  always_comb irq_d = |(status_d & ~mask_d);

  always_ff @(posedge clk or negedge srst_ni) begin
    if (!srst_ni) irq_o <= 1'b0;
    else          irq_o <= irq_d;
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_mask_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_i,
  output logic              irq_o
);
  logic              srst_n;
  logic              we_clr, we_unmask, we_mset, we_inj;
  logic [DATA_W-1:0] status_d, status_q;
  logic [DATA_W-1:0] mask_d, mask_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .srst_no(srst_n)
  );

  always_comb begin
    we_clr    = bus_we && (bus_addr == OFF_STATUS);
    we_unmask = bus_we && (bus_addr == OFF_UNMASK);
    we_mset   = bus_we && (bus_addr == OFF_MSET);
    we_inj    = bus_we && (bus_addr == OFF_INJECT);
  end

  irq_status_bank #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .srst_ni(srst_n), .clr_we(we_clr), .inj_we(we_inj),
    .wdata(bus_wdata), .evt_i(evt_i), .status_d(status_d), .status_q(status_q)
  );

  irq_mask_bank #(.DATA_W(DATA_W)) u_mask (
    .clk(clk), .srst_ni(srst_n), .unmask_we(we_unmask), .mset_we(we_mset),
    .wdata(bus_wdata), .mask_d(mask_d), .mask_q(mask_q)
  );

  irq_level_gen #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .srst_ni(srst_n), .status_d(status_d), .mask_d(mask_d),
    .irq_o(irq_o)
  );

  always_comb begin
    unique case (bus_addr)
      OFF_STATUS: bus_rdata = status_q;
      OFF_MASK:   bus_rdata = mask_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_regs_chk.sv
module irq_mask_regs_chk
  import irq_mask_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] evt_i,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq_o
);
  assert_irq_level_R1: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o == |(status_q & ~mask_q));

  assert_unmask_clears_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == OFF_UNMASK) |=> ((mask_q & $past(bus_wdata)) == '0));

  assert_mset_sets_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == OFF_MSET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_inject_sets_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == OFF_INJECT) |=> ((status_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_we && (bus_addr == OFF_UNMASK || bus_addr == OFF_MSET)) |=> $stable(mask_q));

  assert_rdzero_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr != OFF_STATUS && bus_addr != OFF_MASK) |-> (bus_rdata == '0));
endmodule

bind irq_mask_regs irq_mask_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
  .status_q(status_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/irq_mask_regs_tb.sv
module irq_mask_regs_tb;
  localparam int W = 32;

  typedef struct packed {
    logic         we;
    logic [2:0]   addr;
    logic [W-1:0] data;
    logic [W-1:0] evt;
    logic [W-1:0] exp_s;
    logic [W-1:0] exp_m;
    logic         exp_irq;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 3'd4, 32'h0000_00F0, 32'h0, 32'h0000_00F0, 32'hFFFF_FFFF, 1'b0},
    '{1'b1, 3'd2, 32'h0000_0030, 32'h0, 32'h0000_00F0, 32'hFFFF_FFCF, 1'b1},
    '{1'b1, 3'd0, 32'h0000_0010, 32'h0, 32'h0000_00E0, 32'hFFFF_FFCF, 1'b1},
    '{1'b1, 3'd0, 32'h0000_0020, 32'h0, 32'h0000_00C0, 32'hFFFF_FFCF, 1'b0},
    '{1'b1, 3'd3, 32'h0000_0010, 32'h0, 32'h0000_00C0, 32'hFFFF_FFDF, 1'b0},
    '{1'b1, 3'd1, 32'h0000_0000, 32'h0, 32'h0000_00C0, 32'hFFFF_FFDF, 1'b0},
    '{1'b0, 3'd0, 32'h0000_0000, 32'h0000_0020, 32'h0000_00E0, 32'hFFFF_FFDF, 1'b1},
    '{1'b1, 3'd2, 32'hFFFF_0000, 32'h0, 32'h0000_00E0, 32'h0000_FFDF, 1'b1},
    '{1'b1, 3'd4, 32'h8000_0000, 32'h0, 32'h8000_00E0, 32'h0000_FFDF, 1'b1},
    '{1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0, 32'h8000_00E0, 32'hFFFF_FFFF, 1'b0}
  };

  logic         clk;
  logic         rst_ni;
  logic         bus_we;
  logic [2:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] evt_i;
  logic         irq_o;

  int checks;
  int failures;
  bit done;

  irq_mask_regs #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_ni(rst_ni), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_state(input string req, input logic [W-1:0] s,
                             input logic [W-1:0] m, input logic irq);
    logic [W-1:0] d;
    chk({req, " irq"}, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, irq});
    read_at(3'd0, d);
    chk({req, " status"}, d, s);
    read_at(3'd1, d);
    chk({req, " mask"}, d, m);
  endtask

  task automatic cycle(input logic we, input logic [2:0] a,
                       input logic [W-1:0] d, input logic [W-1:0] e);
    bus_we = we; bus_addr = a; bus_wdata = d; evt_i = e;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; evt_i = '0; bus_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    checks = 0; failures = 0; done = 1'b0;
    rst_ni = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    // R7: values held during reset
    check_state("R7 in-reset", 32'h0, 32'hFFFF_FFFF, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_state("R7 after-release", 32'h0, 32'hFFFF_FFFF, 1'b0);

    // Vector walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].evt);
      check_state($sformatf("R1-vec%0d", i), VEC[i].exp_s, VEC[i].exp_m, VEC[i].exp_irq);
    end

    // R6: clear and event on bit 5 in the same cycle, event wins
    cycle(1'b1, 3'd0, 32'h0000_0020, 32'h0000_0020);
    check_state("R6 same-cycle", 32'h8000_00E0, 32'hFFFF_FFFF, 1'b0);

    // R5: clearing bit 31 while bits 5..7 stay set
    cycle(1'b1, 3'd0, 32'h8000_0000, 32'h0);
    check_state("R5 clear-msb", 32'h0000_00E0, 32'hFFFF_FFFF, 1'b0);

    // R8: write-only and unmapped offsets read as zero
    for (int a = 2; a < 8; a++) begin
      read_at(a[2:0], d);
      chk($sformatf("R8 rd-offset%0d", a), d, 32'h0);
    end

    // R1: unmask bit 6 raises irq, clearing it drops irq
    cycle(1'b1, 3'd2, 32'h0000_0040, 32'h0);
    check_state("R1 unmask", 32'h0000_00E0, 32'hFFFF_FFBF, 1'b1);
    cycle(1'b1, 3'd0, 32'h0000_0040, 32'h0);
    check_state("R1 cleared", 32'h0000_00A0, 32'hFFFF_FFBF, 1'b0);

    // R7: reset in mid-run restores reset values asynchronously
    cycle(1'b1, 3'd0, 32'h0, 32'h0000_0040);
    check_state("R7 pre-reset", 32'h0000_00E0, 32'hFFFF_FFBF, 1'b1);
    rst_ni = 1'b0;
    #1;
    check_state("R7 mid-run", 32'h0, 32'hFFFF_FFFF, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_state("R7 re-release", 32'h0, 32'hFFFF_FFFF, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule